// File: doc/BRIEF.md
# Packed Float/Integer Converter

This block converts between 32-bit single-precision floats and signed integers on a 64-bit packed operand that carries two independent 32-bit lanes. One operation select chooses among four conversions: full 32-bit integer to float, float to full 32-bit integer, signed 16-bit integer to float, and float to signed 16-bit integer sign-extended to 32 bits. Both lanes always take the same conversion.

The float format is the usual single-precision layout: sign in bit 31, an 8-bit biased exponent (bias 127) in bits 30:23 and a 23-bit fraction with a hidden leading one in bits 22:0. The rules are simplified. Every conversion truncates toward zero. A float whose exponent field is zero counts as zero. No infinities, NaNs or status flags exist. Out-of-range float inputs clamp to the limits of the target integer width.

An operand and a select are presented with a valid strobe. The packed result appears with its own valid strobe a fixed two cycles later. The converter can accept a new operand every cycle.

Top module: `pkcvt`

## Requirements
- R1: `valid_o` is `valid_i` delayed by exactly two clock cycles. A result is presented on `res_o` in the cycle in which `valid_o` is high.
- R2: Each lane converts independently. Lane k uses input bits [32k+31:32k] and produces output bits [32k+31:32k].
- R3: Select 8'h0D turns a 32-bit two's-complement integer into a float. Bits that do not fit in the 24-bit significand are dropped, so the result is truncated toward zero (0x7FFFFFFF gives 0x4EFFFFFF). 0x80000000 gives 0xCF000000.
- R4: An integer input of zero, under either integer-to-float select, gives the all-zero word (+0.0).
- R5: Select 8'h1D turns a float into a 32-bit signed integer, truncated toward zero (-2.7 gives -2).
- R6: Under either float-to-integer select, a float with exponent field 00h gives 0. So does any float with magnitude below 1.0.
- R7: Under select 8'h1D, a float at or beyond 2^31 in magnitude gives 0x7FFFFFFF when positive and 0x80000000 when negative.
- R8: Select 8'h0C takes bits [15:0] of each lane as a signed 16-bit value and converts it to a float. Bits [31:16] of the lane have no effect.
- R9: Select 8'h1C turns a float into a 16-bit signed integer, truncated toward zero. The value clamps to 0x7FFF or 0x8000 and is sign-extended through bits [31:16] of the lane.
- R10: Any other select value gives an all-zero result, and `valid_o` is still asserted.
- R11: While `rst_ni` is low, `valid_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and select are valid |
| op_i | input | 8 | Conversion select |
| src_i | input | 64 | Packed operand, two 32-bit lanes |
| valid_o | output | 1 | Result valid, two cycles after `valid_i` |
| res_o | output | 64 | Packed result, two 32-bit lanes |

## Verification
Directed cases target the places where truncation and rounding to nearest give different results:
- an all-ones 31-bit magnitude, which would round up to the next power of two;
- a negative fraction, which must move toward zero and not down.

Further directed cases check the range edges: the most negative 32-bit integer, values below 1.0, an exponent field of zero, and values beyond both the 32-bit and the 16-bit limits in each sign. They also check that only the low half of a lane is read under the word-to-float select, and that an unknown select gives zero. Random operands, with exponents drawn around the range where the result is representable, mix all four selects and different values in the two lanes. This shows that the lanes stay separate and that the shift and normalise logic is right across every exponent position.

// File: rtl/pkcvt_pkg.sv
package pkcvt_pkg;
  localparam int LANE_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int HALF_W = 16;
  localparam int OP_W   = 8;

  typedef enum logic [OP_W-1:0] {
    OP_I2F_D = 8'h0D,
    OP_F2I_D = 8'h1D,
    OP_I2F_W = 8'h0C,
    OP_F2I_W = 8'h1C
  } op_e;

  typedef struct packed {
    logic to_flt;
    logic word;
    logic ok;
  } mode_t;

  function automatic mode_t decode_op(input logic [OP_W-1:0] op);
    mode_t m;
    m = '0;
    case (op)
      OP_I2F_D: m = '{to_flt: 1'b1, word: 1'b0, ok: 1'b1};
      OP_F2I_D: m = '{to_flt: 1'b0, word: 1'b0, ok: 1'b1};
      OP_I2F_W: m = '{to_flt: 1'b1, word: 1'b1, ok: 1'b1};
      OP_F2I_W: m = '{to_flt: 1'b0, word: 1'b1, ok: 1'b1};
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pkcvt_i2f.sv
module pkcvt_i2f #(
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [LANE_W-1:0] int_i,
  output logic [LANE_W-1:0] flt_o
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int IDX_W = $clog2(LANE_W);

  logic              neg;
  logic [LANE_W-1:0] mag;
  logic [LANE_W-1:0] norm;
  logic [IDX_W-1:0]  lead;
  logic [EXP_W-1:0]  ex;

  always_comb begin
    neg  = int_i[LANE_W-1];
    mag  = neg ? (~int_i + 1'b1) : int_i;
    lead = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (mag[i]) lead = IDX_W'(i);
    end
    // left-justify so the leading one sits at LANE_W-1; low bits fall off (truncate)
    norm  = mag << (IDX_W'(LANE_W - 1) - lead);
    ex    = EXP_W'(BIAS) + EXP_W'(lead);
    flt_o = (mag == '0) ? '0 : {neg, ex, norm[LANE_W-2 -: FRAC_W]};
  end
endmodule

// File: rtl/pkcvt_f2i.sv
module pkcvt_f2i #(
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int HALF_W = 16
) (
  input  logic [LANE_W-1:0] flt_i,
  input  logic              word_i,
  output logic [LANE_W-1:0] int_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [EXP_W-1:0]  amt;
  logic [EXP_W-1:0]  lim;
  logic [FRAC_W-1:0] frac;
  logic [LANE_W-1:0] sig;
  logic [LANE_W-1:0] mag;
  logic [LANE_W-1:0] pos_sat;

  always_comb begin
    sgn     = flt_i[LANE_W-1];
    ex      = flt_i[LANE_W-2 -: EXP_W];
    frac    = flt_i[FRAC_W-1:0];
    sig     = LANE_W'({1'b1, frac});
    amt     = ex - EXP_W'(BIAS);
    lim     = word_i ? EXP_W'(HALF_W - 1) : EXP_W'(LANE_W - 1);
    pos_sat = word_i ? LANE_W'((1 << (HALF_W - 1)) - 1) : {1'b0, {(LANE_W-1){1'b1}}};
    mag     = (amt <= EXP_W'(FRAC_W)) ? (sig >> (EXP_W'(FRAC_W) - amt))
                                      : (sig << (amt - EXP_W'(FRAC_W)));
    if (ex < EXP_W'(BIAS))      int_o = '0;  // covers exponent 00h and |x| < 1
    else if (amt >= lim)        int_o = sgn ? ~pos_sat : pos_sat;
    else                        int_o = sgn ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/pkcvt_lane.sv
module pkcvt_lane
  import pkcvt_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int HALF_W = 16
) (
  input  mode_t             mode_i,
  input  logic [LANE_W-1:0] src_i,
  output logic [LANE_W-1:0] res_o
);
  logic [LANE_W-1:0] int_in;
  logic [LANE_W-1:0] flt_res;
  logic [LANE_W-1:0] int_res;

  assign int_in = mode_i.word ? {{(LANE_W-HALF_W){src_i[HALF_W-1]}}, src_i[HALF_W-1:0]}
                              : src_i;

  pkcvt_i2f #(.LANE_W(LANE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_i2f (
    .int_i (int_in),
    .flt_o (flt_res)
  );

  pkcvt_f2i #(.LANE_W(LANE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .HALF_W(HALF_W)) u_f2i (
    .flt_i  (src_i),
    .word_i (mode_i.word),
    .int_o  (int_res)
  );

  always_comb begin
    if (!mode_i.ok)         res_o = '0;
    else if (mode_i.to_flt) res_o = flt_res;
    else                    res_o = int_res;
  end
endmodule

// File: rtl/pkcvt.sv
module pkcvt
  import pkcvt_pkg::*;
#(
  parameter  int LANES  = 2,
  localparam int PACK_W = LANES * pkcvt_pkg::LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [PACK_W-1:0] src_i,
  output logic              valid_o,
  output logic [PACK_W-1:0] res_o
);
  logic              v1_q;
  mode_t             mode_q;
  logic [PACK_W-1:0] src_q;
  logic [PACK_W-1:0] res_d;

  // stage 1: capture operand and decoded select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      mode_q <= '0;
      src_q  <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        mode_q <= decode_op(op_i);
        src_q  <= src_i;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pkcvt_lane #(.LANE_W(LANE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .HALF_W(HALF_W)) u_lane (
      .mode_i (mode_q),
      .src_i  (src_q[g*LANE_W +: LANE_W]),
      .res_o  (res_d[g*LANE_W +: LANE_W])
    );
  end

  // stage 2: register result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) res_o <= res_d;
    end
  end
endmodule

// File: rtl/pkcvt_chk.sv
module pkcvt_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [7:0]              op_i,
  input logic [LANES*LANE_W-1:0] src_i,
  input logic                    valid_o,
  input logic [LANES*LANE_W-1:0] res_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R11
  rst_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0));

  // R10
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && $past(valid_i, 2) &&
     !($past(op_i, 2) inside {8'h0D, 8'h1D, 8'h0C, 8'h1C})) |-> (res_o == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4
    zero_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2 && $past(valid_i, 2) && $past(op_i, 2) == 8'h0D &&
       $past(src_i[g*LANE_W +: LANE_W], 2) == '0) |-> (res_o[g*LANE_W +: LANE_W] == '0));

    // R6
    zero_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2 && $past(valid_i, 2) && ($past(op_i, 2) inside {8'h1D, 8'h1C}) &&
       $past(src_i[g*LANE_W+23 +: 8], 2) == 8'h00) |-> (res_o[g*LANE_W +: LANE_W] == '0));

    // R9
    word_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2 && $past(valid_i, 2) && $past(op_i, 2) == 8'h1C) |->
      (res_o[g*LANE_W+15 +: 17] == '0 || res_o[g*LANE_W+15 +: 17] == '1));
  end
endmodule

bind pkcvt pkcvt_chk #(.LANES(LANES), .LANE_W(pkcvt_pkg::LANE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .src_i   (src_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/pkcvt_tb.sv
`timescale 1ns/1ps
module pkcvt_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [7:0]  op_i;
  logic [63:0] src_i;
  logic        valid_o;
  logic [63:0] res_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pkcvt u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .op_i (op_i),
    .src_i (src_i), .valid_o (valid_o), .res_o (res_o)
  );

  function automatic logic [31:0] ref_i2f(input logic [31:0] x);
    longint m;
    int e;
    logic s;
    if (x == 32'd0) return 32'd0;
    s = x[31];
    m = s ? (64'd4294967296 - longint'(x)) : longint'(x);
    e = 150;
    while (m >= 64'd16777216) begin m = m >> 1; e++; end
    while (m < 64'd8388608)   begin m = m << 1; e--; end
    return {s, 8'(e), m[22:0]};
  endfunction

  function automatic logic [31:0] ref_f2i(input logic [31:0] f, input bit word);
    int e;
    longint sig, v, lim;
    e   = int'(f[30:23]);
    sig = longint'({1'b1, f[22:0]});
    lim = word ? 64'd32767 : 64'd2147483647;
    if (e == 0) return 32'd0;
    if (e >= 190)      v = lim + 2;
    else if (e >= 150) v = sig << (e - 150);
    else if (e >= 126) v = sig >> (150 - e);
    else               v = 0;
    if (!f[31]) v = (v > lim) ? lim : v;
    else        v = (v > lim + 1) ? -(lim + 1) : -v;
    return v[31:0];
  endfunction

  function automatic logic [31:0] ref_lane(input logic [7:0] op, input logic [31:0] x);
    case (op)
      8'h0D:   return ref_i2f(x);
      8'h1D:   return ref_f2i(x, 1'b0);
      8'h0C:   return ref_i2f({{16{x[15]}}, x[15:0]});
      8'h1C:   return ref_f2i(x, 1'b1);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [7:0] op, input logic [63:0] src,
                     input logic [63:0] exp);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; src_i = src;
    @(negedge clk_i);
    valid_i = 1'b0; src_i = ~src; op_i = 8'hFF;
    check({tag, " R1 early valid"}, {63'd0, valid_o}, 64'd0);
    @(negedge clk_i);
    check({tag, " R1 valid"}, {63'd0, valid_o}, 64'd1);
    check(tag, res_o, exp);
  endtask

  function automatic logic [31:0] rnd_flt();
    logic [7:0] e;
    e = ($urandom % 16 == 0) ? 8'd0 : 8'(100 + $urandom % 70);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    logic [7:0] ops [4];
    ops[0] = 8'h0D; ops[1] = 8'h1D; ops[2] = 8'h0C; ops[3] = 8'h1C;
    void'($urandom(32'd7));
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; src_i = '0;
    repeat (3) @(negedge clk_i);
    check("R11 reset valid", {63'd0, valid_o}, 64'd0);
    check("R11 reset data", res_o, 64'd0);
    rst_ni = 1'b1;

    run("R4 R2 i2f zero/one", 8'h0D, {32'd1, 32'd0}, {32'h3F800000, 32'h0});
    run("R3 i2f truncate", 8'h0D, {32'h7FFFFFFF, 32'h80000000}, {32'h4EFFFFFF, 32'hCF000000});
    run("R3 i2f neg truncate", 8'h0D, {32'hFEFFFFFF, 32'd0}, {ref_i2f(32'hFEFFFFFF), 32'h0});
    run("R5 R6 f2i trunc", 8'h1D, {32'hC02CCCCD, 32'h3F400000}, {32'hFFFFFFFE, 32'h0});
    run("R6 f2i exp zero", 8'h1D, {32'h00400000, 32'h80700000}, 64'd0);
    run("R7 f2i saturate", 8'h1D, {32'h501502F9, 32'hD01502F9}, {32'h7FFFFFFF, 32'h80000000});
    run("R8 w2f low half", 8'h0C, {32'hABCD8000, 32'h12340005}, {32'hC7000000, 32'h40A00000});
    run("R4 w2f zero", 8'h0C, {32'hFFFF0000, 32'h00010000}, 64'd0);
    run("R9 f2w saturate", 8'h1C, {32'h4788B800, 32'hC788B800}, {32'h00007FFF, 32'hFFFF8000});
    run("R9 f2w trunc", 8'h1C, {32'hC0B00000, 32'h46FFFE00}, {32'hFFFFFFFB, 32'h00007FFF});
    run("R10 bad op", 8'hB4, {32'h3F800000, 32'd5}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0]  op;
      logic [31:0] a, b;
      op = ($urandom % 20 == 0) ? 8'($urandom) : ops[$urandom % 4];
      if (op == 8'h1D || op == 8'h1C) begin a = rnd_flt(); b = rnd_flt(); end
      else begin a = $urandom; b = ($urandom % 8 == 0) ? 32'd0 : $urandom >> ($urandom % 32); end
      run("R2 R3 R5 R8 R9 random", op, {a, b}, {ref_lane(op, a), ref_lane(op, b)});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule